// File: doc/BRIEF.md
# Programmable Vertical Blanking Window Generator

This block produces a vertical blanking flag for a video decoder. Its rising and falling edges follow the standard blanking interval of the current video standard, and each edge can be moved independently by a whole number of lines. Upstream logic supplies a line strobe, the index of the current line, a field start pulse, the number of lines in a field and the standard first and last-plus-one blanking lines. The block adds a signed offset to each standard boundary. Each offset is held in its own 8-bit code, and the offset codes are captured once per field.

The same adjusted window also enables the luma bypass path, so bypass lasts exactly as long as blanking. A general-purpose output pin carries either the blanking flag or an alternate signal from elsewhere in the chip, chosen by a select input.

Top module: `vblank_window_gen`

## Requirements
- R1: After reset is released, and before any line strobe, `vblank_o`, `luma_byp_o` and `gp_o` (with `gp_sel_i`=0) are 0, and both captured offset codes are 0x00.
- R2: Offset code 0x00 leaves its edge on the standard boundary. Code 0x80 does the same. Codes 0x01 to 0x7F move the edge later by the code value in lines (bits [6:0]).
- R3: Codes 0x81 to 0xFE move the edge earlier by bits [6:0] in lines. Code 0xFF moves the edge 128 lines earlier.
- R4: The flag is 1 on lines L with start ≤ L < stop. When stop < start, the window wraps across the field boundary and the flag is 1 on L ≥ start or L < stop. When start equals stop, the flag stays 0.
- R5: The effective start and stop lines equal (standard line + offset) modulo `lines_per_field_i`.
- R6: Offset codes are captured only on a cycle with `field_start_i`=1, and they apply from the line strobed in that cycle. A code change at any other time has no effect until the next field start.
- R7: `vblank_o` and `luma_byp_o` are registered. They take the value for `line_idx_i` one clock after a cycle with `line_stb_i`=1, and they hold in every cycle without a strobe.
- R8: With `gp_sel_i`=0, `gp_o` equals `vblank_o`. With `gp_sel_i`=1, `gp_o` equals `alt_i`.
- R9: `luma_byp_o` follows the adjusted window whatever the value of `gp_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_stb_i | input | 1 | One-cycle pulse per video line |
| field_start_i | input | 1 | Field start pulse, given with the strobe of line 0 |
| line_idx_i | input | LINE_W | Current line within the field |
| lines_per_field_i | input | LINE_W | Total lines in a field |
| std_start_i | input | LINE_W | Standard first blanking line |
| std_stop_i | input | LINE_W | Standard line at which blanking ends |
| start_ofs_i | input | OFS_W | Start edge offset code |
| stop_ofs_i | input | OFS_W | Stop edge offset code |
| gp_sel_i | input | 1 | Pin function: 0 blanking flag, 1 alternate |
| alt_i | input | 1 | Alternate pin source |
| vblank_o | output | 1 | Adjusted blanking flag |
| gp_o | output | 1 | General-purpose pin value |
| luma_byp_o | output | 1 | Luma bypass enable |

## Verification
The flag and the bypass enable for a line are due exactly one clock after the strobe that presents that line, and the pin mux is due in the same cycle as its inputs. The bench drives each strobe on a falling edge and reads the result on the next falling edge, before it drives the next line. It sweeps every start code and every stop code over full fields, and it checks each line against window arithmetic it computes itself. Code changes are applied mid-field to test field capture, and strobes are withheld to test that the outputs hold. Both of these are checked at the same falling-edge point.

// File: rtl/vbw_pkg.sv
package vbw_pkg;
  typedef enum logic {
    GP_VBLANK = 1'b0,
    GP_ALT    = 1'b1
  } gp_fn_e;

  localparam int unsigned EDGE_START = 0;
  localparam int unsigned EDGE_STOP  = 1;
  localparam int unsigned N_EDGES    = 2;
endpackage

// File: rtl/vbw_ofs_decode.sv
// Offset code -> signed line delta; msb set means earlier, all-ones is the extreme.
module vbw_ofs_decode #(
  parameter int unsigned OFS_W = 8
) (
  input  logic [OFS_W-1:0]        code_i,
  output logic signed [OFS_W:0]   delta_o
);
  localparam logic signed [OFS_W:0] MIN_D = {2'b11, {(OFS_W-1){1'b0}}};

  logic [OFS_W-2:0] mag;
  assign mag = code_i[OFS_W-2:0];

  always_comb begin
    if (!code_i[OFS_W-1])  delta_o = $signed({2'b00, mag});
    else if (&code_i)      delta_o = MIN_D;
    else                   delta_o = -$signed({2'b00, mag});
  end
endmodule

// File: rtl/vbw_edge_calc.sv
module vbw_edge_calc #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned OFS_W  = 8
) (
  input  logic [LINE_W-1:0]       std_line_i,
  input  logic signed [OFS_W:0]   delta_i,
  input  logic [LINE_W-1:0]       lines_i,
  output logic [LINE_W-1:0]       eff_o
);
  localparam int unsigned SUM_W = LINE_W + 2;

  logic signed [SUM_W-1:0] sum, n_ext, wrapped;

  assign n_ext = $signed({2'b00, lines_i});
  assign sum   = $signed({2'b00, std_line_i}) +
                 $signed({{(SUM_W-OFS_W-1){delta_i[OFS_W]}}, delta_i});

  always_comb begin
    if (sum < 0)           wrapped = sum + n_ext;
    else if (sum >= n_ext) wrapped = sum - n_ext;
    else                   wrapped = sum;
  end

  assign eff_o = wrapped[LINE_W-1:0];
endmodule

// File: rtl/vbw_window.sv
module vbw_window #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_idx_i,
  input  logic [LINE_W-1:0] start_i,
  input  logic [LINE_W-1:0] stop_i,
  input  logic [LINE_W-1:0] lines_i,
  output logic              flag_o
);
  logic in_win, flag_q;

  always_comb begin
    if (start_i == stop_i)     in_win = 1'b0;
    else if (start_i < stop_i) in_win = (line_idx_i >= start_i) && (line_idx_i < stop_i);
    else                       in_win = (line_idx_i >= start_i) || (line_idx_i < stop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (line_stb_i) flag_q <= in_win;
  end

  assign flag_o = flag_q;

  assert_hold_no_stb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable(flag_q));

  assert_start_line_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_stb_i && line_idx_i == start_i && start_i != stop_i && start_i < lines_i)
      |=> flag_q);
endmodule

// File: rtl/vblank_window_gen.sv
module vblank_window_gen
  import vbw_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned OFS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_stb_i,
  input  logic              field_start_i,
  input  logic [LINE_W-1:0] line_idx_i,
  input  logic [LINE_W-1:0] lines_per_field_i,
  input  logic [LINE_W-1:0] std_start_i,
  input  logic [LINE_W-1:0] std_stop_i,
  input  logic [OFS_W-1:0]  start_ofs_i,
  input  logic [OFS_W-1:0]  stop_ofs_i,
  input  logic              gp_sel_i,
  input  logic              alt_i,
  output logic              vblank_o,
  output logic              gp_o,
  output logic              luma_byp_o
);
  logic [N_EDGES-1:0][OFS_W-1:0]  code_live, code_q, code_use;
  logic [N_EDGES-1:0][LINE_W-1:0] std_line, eff_line;
  logic signed [OFS_W:0]          delta [N_EDGES];
  logic                           win_flag;

  assign code_live[EDGE_START] = start_ofs_i;
  assign code_live[EDGE_STOP]  = stop_ofs_i;
  assign std_line[EDGE_START]  = std_start_i;
  assign std_line[EDGE_STOP]   = std_stop_i;

  for (genvar e = 0; e < N_EDGES; e++) begin : g_edge
    // shadow code, refreshed only at field start
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            code_q[e] <= '0;
      else if (field_start_i) code_q[e] <= code_live[e];
    end

    assign code_use[e] = field_start_i ? code_live[e] : code_q[e];

    vbw_ofs_decode #(.OFS_W(OFS_W)) u_dec (
      .code_i  (code_use[e]),
      .delta_o (delta[e])
    );

    vbw_edge_calc #(.LINE_W(LINE_W), .OFS_W(OFS_W)) u_calc (
      .std_line_i (std_line[e]),
      .delta_i    (delta[e]),
      .lines_i    (lines_per_field_i),
      .eff_o      (eff_line[e])
    );

    assert_eff_in_field_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (std_line[e] < lines_per_field_i && lines_per_field_i > LINE_W'(2**(OFS_W-1)))
        |-> eff_line[e] < lines_per_field_i);

    assert_code_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !field_start_i |=> $stable(code_q[e]));
  end

  vbw_window #(.LINE_W(LINE_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_stb_i (line_stb_i),
    .line_idx_i (line_idx_i),
    .start_i    (eff_line[EDGE_START]),
    .stop_i     (eff_line[EDGE_STOP]),
    .lines_i    (lines_per_field_i),
    .flag_o     (win_flag)
  );

  assign vblank_o   = win_flag;
  assign luma_byp_o = win_flag;
  assign gp_o       = (gp_fn_e'(gp_sel_i) == GP_ALT) ? alt_i : win_flag;
endmodule

// File: tb/vblank_window_gen_tb.sv
module vblank_window_gen_tb;
  localparam int LINE_W = 10;
  localparam int OFS_W  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_stb = 0, field_start = 0, gp_sel = 0, alt = 0;
  logic [LINE_W-1:0] line_idx = '0, lines = 10'd262, s_std = 10'd1, e_std = 10'd20;
  logic [OFS_W-1:0] s_code = '0, e_code = '0;
  logic vblank, gp, luma;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vblank_window_gen #(.LINE_W(LINE_W), .OFS_W(OFS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_stb_i(line_stb), .field_start_i(field_start),
    .line_idx_i(line_idx), .lines_per_field_i(lines), .std_start_i(s_std),
    .std_stop_i(e_std), .start_ofs_i(s_code), .stop_ofs_i(e_code),
    .gp_sel_i(gp_sel), .alt_i(alt), .vblank_o(vblank), .gp_o(gp), .luma_byp_o(luma));

  function automatic int dec(input logic [7:0] c);
    if (!c[7]) return int'(c);
    if (c == 8'hFF) return -128;
    return -int'(c[6:0]);
  endfunction

  function automatic int eff(input int std, input logic [7:0] c, input int n);
    int v = std + dec(c);
    if (v < 0) v += n;
    if (v >= n) v -= n;
    return v;
  endfunction

  function automatic bit inwin(input int l, input int s, input int e);
    if (s == e) return 0;
    if (s < e) return (l >= s) && (l < e);
    return (l >= s) || (l < e);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one field, one line per cycle; codes cs/ce applied at field start,
  // live inputs switched to cs2/ce2 at line chg (must not affect this field)
  task automatic run_field(input string req, input logic [7:0] cs, input logic [7:0] ce,
                           input logic [7:0] cs2, input logic [7:0] ce2, input int chg);
    int n = int'(lines);
    int es = eff(int'(s_std), cs, n);
    int ee = eff(int'(e_std), ce, n);
    s_code = cs; e_code = ce;
    for (int l = 0; l < n; l++) begin
      if (l == chg) begin s_code = cs2; e_code = ce2; end
      line_idx = LINE_W'(l); line_stb = 1; field_start = (l == 0);
      @(negedge clk);
      chk(req, {30'd0, vblank, luma}, inwin(l, es, ee) ? 3 : 0);
    end
    line_stb = 0; field_start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {29'd0, vblank, luma, gp}, 0);
    // R1: captured codes are zero -> default window [1,20) without a field start
    line_idx = 10'd5; line_stb = 1; s_code = 8'h40; e_code = 8'h40;
    @(negedge clk);
    line_stb = 0;
    chk("R1", int'(vblank), 1);

    // R2 / R3: sweep every start code, then every stop code
    for (int c = 0; c < 256; c++)
      run_field(c[7] && c != 128 ? "R3" : "R2", 8'(c), 8'h00, 8'(c), 8'h00, 1000);
    for (int c = 0; c < 256; c++)
      run_field(c[7] && c != 128 ? "R3" : "R2", 8'h00, 8'(c), 8'h00, 8'(c), 1000);

    // R4: wrapping window and empty window
    run_field("R4", 8'hFF, 8'h05, 8'hFF, 8'h05, 1000);
    run_field("R4", 8'h13, 8'h00, 8'h13, 8'h00, 1000);

    // R5: other field length, standard interval itself wrapping
    lines = 10'd313; s_std = 10'd300; e_std = 10'd10;
    run_field("R5", 8'h20, 8'h7F, 8'h20, 8'h7F, 1000);
    run_field("R5", 8'hFF, 8'hA0, 8'hFF, 8'hA0, 1000);
    lines = 10'd262; s_std = 10'd1; e_std = 10'd20;

    // R6: mid-field change ignored, then used at next field start
    run_field("R6", 8'h05, 8'h02, 8'h30, 8'h81, 10);
    run_field("R6", 8'h30, 8'h81, 8'h30, 8'h81, 1000);

    // R7: no strobe -> hold, though the index now lies outside the window
    line_idx = 10'd40; line_stb = 1; field_start = 1; s_code = 8'h00; e_code = 8'h40;
    @(negedge clk);
    line_stb = 0; field_start = 0;
    chk("R7", int'(vblank), 1);
    line_idx = 10'd200;
    repeat (5) @(negedge clk);
    chk("R7", {30'd0, vblank, luma}, 3);
    line_stb = 1;
    @(negedge clk);
    line_stb = 0;
    chk("R7", {30'd0, vblank, luma}, 0);

    // R8 / R9: pin mux and bypass independence
    chk("R8", int'(gp), 0);
    gp_sel = 1; alt = 1; #1;
    chk("R8", int'(gp), 1);
    line_idx = 10'd50; line_stb = 1;
    @(negedge clk);
    line_stb = 0;
    chk("R9", int'(luma), 1);
    chk("R8", int'(gp), 1);
    alt = 0; #1;
    chk("R8", int'(gp), 0);
    gp_sel = 0; #1;
    chk("R8", int'(gp), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule